// File: doc/BRIEF.md
# Serial Lane Reconfiguration and Training Sequencer

This block brings one high-speed serial lane from its default setup into backplane operation and then oversees link training. A start request drives both of the lane's resets low and holds them for a minimum time. It then issues a one-cycle request for new per-lane settings and waits for that request to be acknowledged. After a second minimum wait it releases both resets at once. Training is then enabled, and the training status inputs are watched.

A reported training failure sends the lane back through the full reset, reconfigure and train cycle, and a retry counter goes up by one. The run ends in one of two ways. Success means the ready and frame-lock indications are both high in the same cycle. Timeout means an overall deadline, counted from the accepted start, runs out first. Both minimum waits are given in nanoseconds and converted to clock cycles by rounding up, so the analog timing limits hold for any clock period.

Top module: `lane_reconfig_seq`

## Requirements
- R1: While the settings request is high, both lane resets are low. The resets stay low from the first hold cycle through the last settle cycle.
- R2: After an accepted start or a training failure, both resets are low for exactly HOLD cycles before the settings request rises. HOLD is the smallest cycle count whose duration is at least HOLD_NS. The defaults give 13 cycles of 4 ns.
- R3: The settings request is high for exactly one cycle. The acknowledge input is sampled only in the cycles after that pulse. The sequencer waits there for as long as it takes.
- R4: After the cycle in which the acknowledge is taken, the resets stay low for exactly SETTLE further cycles. SETTLE is the cycle count for SETTLE_NS, rounded up; the default is 30. Both resets then rise in the same cycle.
- R5: The training enable is high from the cycle the resets are released until a training result is taken. It is low in every other state.
- R6: A training failure without success puts the resets low again in the next cycle, restarts the hold time and adds one to the retry count.
- R7: Success needs ready and frame-lock high in the same cycle. Ready alone does not count. Success takes priority over a failure in the same cycle. The done output is high from the next cycle on.
- R8: Busy lasts at most DEADLINE_CYCLES cycles after an accepted start. If success has not happened by then, the fail output goes high, the resets are released and training is disabled.
- R9: The retry count clears on every accepted start and saturates at its maximum value.
- R10: Busy, done and fail are mutually exclusive. A start request is ignored while busy. It is accepted when idle, done or failed.
- R11: After reset all outputs are low, except the two lane resets, which are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to start a reconfiguration run |
| cfg_req_o | output | 1 | One-cycle request to apply the new lane settings |
| cfg_ack_i | input | 1 | The settings have been applied |
| tx_rst_n_o | output | 1 | Lane transmit reset, active low |
| rx_rst_n_o | output | 1 | Lane receive reset, active low |
| train_en_o | output | 1 | Link training enable |
| train_fail_i | input | 1 | Training reports failure |
| train_ready_i | input | 1 | Training reports status ready |
| frame_lock_i | input | 1 | Training reports frame lock |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run ended in success |
| fail_o | output | 1 | The last run hit the deadline |
| retry_cnt_o | output | RETRY_W | Number of training retries in the current run |

## Verification
Every output is decoded from a state register. An input sampled at one rising edge therefore shows on the outputs in the cycle that follows: the resets fall one cycle after the start, and done or a fresh hold begins one cycle after a training result. The cycle-exact windows R2 and R4 are measured from these points. The bench model advances on each rising edge from the same inputs the design sees. Inputs change, and all outputs are compared with the model, only on the falling edge. The hold length, the settle length and the number of busy cycles before a timeout are also counted directly and checked against values worked out from the time parameters.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_REQ, ST_WACK, ST_SETTLE, ST_TRAIN, ST_DONE, ST_TOUT
  } seq_state_t;

  // Smallest cycle count whose duration reaches the given time, at least one.
  function automatic int ns_to_cycles(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/lane_seq_timer.sv
module lane_seq_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load_i)        cnt <= val_i;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/lane_seq_deadline.sv
module lane_seq_deadline #(
  parameter int LIMIT = 400,
  parameter int W     = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  logic [W-1:0] cnt;

  assign expire_o = run_i && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clear_i)             cnt <= '0;
    else if (run_i && !expire_o)  cnt <= cnt + 1'b1;
  end

  p_within_deadline_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt < W'(LIMIT)));
endmodule

// File: rtl/lane_reconfig_seq.sv
module lane_reconfig_seq
  import lane_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS   = 4000,
  parameter int HOLD_NS         = 50,
  parameter int SETTLE_NS       = 120,
  parameter int DEADLINE_CYCLES = 400,
  parameter int RETRY_W         = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               cfg_req_o,
  input  logic               cfg_ack_i,
  output logic               tx_rst_n_o,
  output logic               rx_rst_n_o,
  output logic               train_en_o,
  input  logic               train_fail_i,
  input  logic               train_ready_i,
  input  logic               frame_lock_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  localparam int HOLD_CYC   = ns_to_cycles(HOLD_NS, CLK_PERIOD_PS);
  localparam int SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_PERIOD_PS);
  localparam int TMR_W      = bits_for((HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC);
  localparam int DL_W       = bits_for(DEADLINE_CYCLES);
  localparam int MON_W      = 16;

  seq_state_t state, nxt;
  logic             tmr_ld, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             ev_start, ev_ack, ev_success, ev_tfail, ev_retry, ev_expire;
  logic             lane_in_reset;

  // Named internal events
  assign busy_o     = (state inside {ST_HOLD, ST_REQ, ST_WACK, ST_SETTLE, ST_TRAIN});
  assign ev_start   = start_i && !busy_o;
  assign ev_ack     = (state == ST_WACK) && cfg_ack_i;
  assign ev_success = (state == ST_TRAIN) && train_ready_i && frame_lock_i;
  assign ev_tfail   = (state == ST_TRAIN) && train_fail_i && !ev_success;
  assign ev_retry   = ev_tfail && !ev_expire;

  lane_seq_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  lane_seq_deadline #(.LIMIT(DEADLINE_CYCLES), .W(DL_W)) u_deadline (
    .clk(clk), .rst_n(rst_n), .clear_i(ev_start), .run_i(busy_o), .expire_o(ev_expire)
  );

  always_comb begin
    nxt     = state;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    if (!busy_o) begin
      if (start_i) begin
        nxt = ST_HOLD; tmr_ld = 1'b1; tmr_val = TMR_W'(HOLD_CYC - 1);
      end
    end else if (ev_success) begin
      nxt = ST_DONE;
    end else if (ev_expire) begin
      nxt = ST_TOUT;
    end else begin
      unique case (state)
        ST_HOLD:   if (tmr_zero) nxt = ST_REQ;
        ST_REQ:    nxt = ST_WACK;
        ST_WACK:   if (ev_ack) begin
                     nxt = ST_SETTLE; tmr_ld = 1'b1; tmr_val = TMR_W'(SETTLE_CYC - 1);
                   end
        ST_SETTLE: if (tmr_zero) nxt = ST_TRAIN;
        ST_TRAIN:  if (ev_tfail) begin
                     nxt = ST_HOLD; tmr_ld = 1'b1; tmr_val = TMR_W'(HOLD_CYC - 1);
                   end
        default:   nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    retry_cnt_o <= '0;
    else if (ev_start)                             retry_cnt_o <= '0;
    else if (ev_retry && (retry_cnt_o != '1))      retry_cnt_o <= retry_cnt_o + 1'b1;
  end

  assign lane_in_reset = (state inside {ST_HOLD, ST_REQ, ST_WACK, ST_SETTLE});
  assign tx_rst_n_o    = !lane_in_reset;
  assign rx_rst_n_o    = !lane_in_reset;
  assign cfg_req_o     = (state == ST_REQ);
  assign train_en_o    = (state == ST_TRAIN);
  assign done_o        = (state == ST_DONE);
  assign fail_o        = (state == ST_TOUT);

  // Window monitors for the assertions
  logic [MON_W-1:0] low_cnt, since_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_cnt <= '0;
    else if (tx_rst_n_o)        low_cnt <= '0;
    else if (low_cnt != '1)     low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         since_ack <= '0;
    else if (ev_ack)                                    since_ack <= MON_W'(1);
    else if (tx_rst_n_o)                                since_ack <= '0;
    else if (since_ack != '0 && since_ack != '1)        since_ack <= since_ack + 1'b1;
  end

  p_req_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_o |-> (!tx_rst_n_o && !rx_rst_n_o));

  p_hold_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_o |-> (low_cnt >= MON_W'(HOLD_CYC)));

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_o |=> !cfg_req_o);

  p_settle_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_rst_n_o) && train_en_o) |-> (since_ack > MON_W'(SETTLE_CYC)));

  p_train_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    train_en_o |-> (tx_rst_n_o && rx_rst_n_o));

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(train_ready_i && frame_lock_i));

  p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, fail_o}));
endmodule

// File: tb/lane_reconfig_seq_bench.sv
module lane_reconfig_seq_bench;
  localparam int PER_PS   = 4000;
  localparam int HOLD_NS  = 50;
  localparam int SETT_NS  = 120;
  localparam int DEADLINE = 400;
  localparam int RW       = 8;
  localparam int ACK_LAT  = 2;
  localparam int TRN_LAT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, cfg_ack_i = 1'b0;
  logic train_fail_i = 1'b0, train_ready_i = 1'b0, frame_lock_i = 1'b0;
  logic cfg_req_o, tx_rst_n_o, rx_rst_n_o, train_en_o, busy_o, done_o, fail_o;
  logic [RW-1:0] retry_cnt_o;

  always #2 clk = ~clk;

  lane_reconfig_seq #(
    .CLK_PERIOD_PS(PER_PS), .HOLD_NS(HOLD_NS), .SETTLE_NS(SETT_NS),
    .DEADLINE_CYCLES(DEADLINE), .RETRY_W(RW)
  ) u_lane_reconfig_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_req_o(cfg_req_o),
    .cfg_ack_i(cfg_ack_i), .tx_rst_n_o(tx_rst_n_o), .rx_rst_n_o(rx_rst_n_o),
    .train_en_o(train_en_o), .train_fail_i(train_fail_i),
    .train_ready_i(train_ready_i), .frame_lock_i(frame_lock_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .retry_cnt_o(retry_cnt_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Minimum cycles to cover a time, found by stepping
  function automatic int min_cycles(input int ns);
    int n = 0;
    while (n * PER_PS < ns * 1000) n++;
    return (n == 0) ? 1 : n;
  endfunction
  int hold_c, sett_c;
  initial begin hold_c = min_cycles(HOLD_NS); sett_c = min_cycles(SETT_NS); end

  // Reference model: phase codes 0 idle,1 hold,2 request,3 await ack,4 settle,5 train,6 done,7 timeout
  int m_ph = 0, m_wait = 0, m_el = 0, m_retry = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_wait = 0; m_el = 0; m_retry = 0;
    end else if (m_ph == 0 || m_ph >= 6) begin
      if (start_i) begin m_ph = 1; m_wait = hold_c; m_el = 0; m_retry = 0; end
    end else if (m_ph == 5 && train_ready_i && frame_lock_i) begin
      m_ph = 6;
    end else if (m_el == DEADLINE - 1) begin
      m_ph = 7;
    end else begin
      m_el++;
      case (m_ph)
        1: begin m_wait--; if (m_wait == 0) m_ph = 2; end
        2: m_ph = 3;
        3: if (cfg_ack_i) begin m_ph = 4; m_wait = sett_c; end
        4: begin m_wait--; if (m_wait == 0) m_ph = 5; end
        5: if (train_fail_i) begin
             m_ph = 1; m_wait = hold_c;
             if (m_retry < (1 << RW) - 1) m_retry++;
           end
        default: ;
      endcase
    end
  end

  // Responder, monitors and per-cycle comparison
  int kinds[$];
  int ack_cd = -1, tc = 0, cur = 0;
  int low_run = 0, hold_seen = -1, pa = 0, settle_seen = -1, busy_run = 0;
  bit pa_on = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 busy",  busy_o,     (m_ph >= 1 && m_ph <= 5));
      chk("R1 txrst",  tx_rst_n_o, !(m_ph >= 1 && m_ph <= 4));
      chk("R4 rxrst",  rx_rst_n_o, !(m_ph >= 1 && m_ph <= 4));
      chk("R3 req",    cfg_req_o,  (m_ph == 2));
      chk("R5 train",  train_en_o, (m_ph == 5));
      chk("R7 done",   done_o,     (m_ph == 6));
      chk("R8 fail",   fail_o,     (m_ph == 7));
      chk("R9 retry",  retry_cnt_o, m_retry);
    end
    if (cfg_req_o) hold_seen = low_run;
    if (!tx_rst_n_o) low_run++; else low_run = 0;
    if (cfg_ack_i) begin pa_on = 1; pa = 0; end
    if (pa_on) begin
      if (!tx_rst_n_o) pa++; else begin settle_seen = pa; pa_on = 0; end
    end
    if (busy_o) busy_run++;
    // drive responses for the next cycle
    cfg_ack_i = 1'b0;
    if (ack_cd == 0) cfg_ack_i = 1'b1;
    if (ack_cd >= 0) ack_cd--;
    if (cfg_req_o) ack_cd = ACK_LAT;
    train_fail_i = 1'b0; train_ready_i = 1'b0; frame_lock_i = 1'b0;
    if (train_en_o) begin
      tc++;
      if (tc == TRN_LAT) begin
        cur = (kinds.size() > 0) ? kinds.pop_front() : 0;
        case (cur)
          1: begin train_ready_i = 1'b1; frame_lock_i = 1'b1; end
          2: train_ready_i = 1'b1;
          3: begin train_ready_i = 1'b1; frame_lock_i = 1'b1; train_fail_i = 1'b1; end
          default: train_fail_i = 1'b1;
        endcase
      end else if (tc == TRN_LAT + 1 && cur == 2) begin
        train_fail_i = 1'b1;
      end
    end else tc = 0;
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000 && !(done_o || fail_o); i++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy_o, 0);  chk("R11 done", done_o, 0);  chk("R11 fail", fail_o, 0);
    chk("R11 tx", tx_rst_n_o, 1); chk("R11 rx", rx_rst_n_o, 1);
    chk("R11 req", cfg_req_o, 0); chk("R11 train", train_en_o, 0);

    // Single pass with immediate success; a start while busy is ignored
    kinds.push_back(1);
    pulse_start();
    repeat (5) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    wait_end();
    chk("R7 done after success", done_o, 1);
    chk("R9 no retries", retry_cnt_o, 0);
    chk("R2 hold cycles", hold_seen, hold_c);
    chk("R4 settle cycles", settle_seen, sett_c);

    // Fail, ready-without-lock then fail, fail together with success
    kinds.push_back(0); kinds.push_back(2); kinds.push_back(3);
    pulse_start();
    wait_end();
    chk("R6 done after retries", done_o, 1);
    chk("R6 retry count", retry_cnt_o, 2);
    chk("R2 hold cycles after retry", hold_seen, hold_c);

    // Training never succeeds: deadline
    busy_run = 0;
    pulse_start();
    wait_end();
    chk("R8 timeout flag", fail_o, 1);
    chk("R8 busy cycles", busy_run, DEADLINE);
    chk("R8 resets released", tx_rst_n_o, 1);
    chk("R8 training off", train_en_o, 0);

    // Restart from timeout
    kinds.push_back(1);
    pulse_start();
    wait_end();
    chk("R10 restart from timeout", done_o, 1);
    chk("R9 retry cleared", retry_cnt_o, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule